// File: doc/BRIEF.md
# Serial Host Interrupt and Error Aggregator

This block sits beside a serial host controller and turns its error and status signals into two interrupt outputs: one for errors and one for events. The datapath sends single-cycle error pulses and three status levels (ready, transmit queue empty, receive queue full). The block latches the errors in a sticky status bank and applies two layers of masking: per-source enables, then a per-line enable. It records a pending bit for each line and drives the line high until software clears that bit.

Software reaches six registers through a word-addressed 32-bit register port. Writes take effect on the clock edge where `reg_we` is high. Reads are combinational from the register state. A test register lets software force either line for one evaluation. A line can only take a new interrupt while its pending bit is clear.

Top module: `ser_irq_hub`

## Requirements
- R1: After reset both interrupt outputs are low, the line-enable, pending, error-status and event-enable registers read 0, and the error-enable register reads 0x1F.
- R2: The register map is: address 0 pending state (bit 0 error line, bit 1 event line, write 1 to clear), 1 line enable (bits 1:0), 2 test (write-only, reads 0), 3 error enable (bits 4:0), 4 error status (bits 5:0, write 1 to clear), 5 event enable (bits 5:0). Written values read back masked to these widths.
- R3: Error-status bits are command busy (0), overflow (1), underflow (2), invalid command (3), invalid chip select (4) and invalid access (5). A pulse on the matching `err_pulse` bit sets the bit. The bit stays set until a 1 is written to it.
- R4: When an error pulse and a write-one-to-clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: The error line's pending bit is set on an edge where line enable bit 0 is set, the pending bit is clear, and either test bit 0 is written in that cycle or one of command busy, invalid command or invalid chip select is flagged and enabled in the error enable. Overflow, underflow and invalid access never raise it.
- R6: The event line's pending bit is set on an edge where line enable bit 1 is set, the pending bit is clear, and either test bit 1 is written or an enabled level is high. The levels are ready (event-enable bit 4), transmit empty (bit 1) and receive full (bit 0). Bits 2, 3 and 5 are stored but have no effect.
- R7: A pending bit stays set until a 1 is written to it in the state register.
- R8: If software clears a pending bit while its cause is still present, the output is low for exactly one cycle and then rises again.
- R9: A test write forces the line for one evaluation only. With the line enable off, it has no effect. After the pending bit is cleared, the line stays low.
- R10: Each output always equals its pending bit ANDed with its line enable as of the last clock edge. Clearing the enable drops the output while the pending bit is kept.
- R11: Reads of addresses 6 and 7 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| err_pulse | input | 6 | Single-cycle error pulses, one bit per error-status bit |
| st_ready | input | 1 | Controller ready for a command |
| st_tx_empty | input | 1 | Transmit queue empty |
| st_rx_full | input | 1 | Receive queue full |
| irq_error | output | 1 | Error interrupt line |
| irq_event | output | 1 | Event interrupt line |

## Verification
Suppose a sticky bit drops or a pending bit fails to latch. The interrupt output then shows the error one edge later, and a read of the status register shows it at once. The bench keeps a behavioural model of every register. It compares both outputs and the read data on every clock, so a wrong state is reported on the first cycle it differs. Directed sequences cover the cases a wrong state could hide in: clearing a bit while its cause persists, colliding set and clear, and masking at each of the two layers.

// File: rtl/ser_irq_pkg.sv
package ser_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int REG_AW   = 3;
    localparam int N_LINE   = 2;
    localparam int N_ERR    = 6;
    localparam int N_ERR_EN = 5;
    localparam int N_EVT    = 6;

    // interrupt line indices
    localparam int LN_ERR = 0;
    localparam int LN_EVT = 1;

    // error-status bit positions
    localparam int EB_CMD_BUSY  = 0;
    localparam int EB_OVERFLOW  = 1;
    localparam int EB_UNDERFLOW = 2;
    localparam int EB_CMD_INVAL = 3;
    localparam int EB_CS_INVAL  = 4;
    localparam int EB_ACCESS    = 5;

    // event-enable bit positions
    localparam int EV_RX_FULL  = 0;
    localparam int EV_TX_EMPTY = 1;
    localparam int EV_RX_WM    = 2;
    localparam int EV_TX_WM    = 3;
    localparam int EV_READY    = 4;
    localparam int EV_IDLE     = 5;

    localparam logic [N_ERR_EN-1:0] ERR_EN_RESET = '1;

    typedef enum logic [REG_AW-1:0] {
        RS_STATE   = 3'd0,
        RS_LINE_EN = 3'd1,
        RS_TEST    = 3'd2,
        RS_ERR_EN  = 3'd3,
        RS_ERR_STS = 3'd4,
        RS_EVT_EN  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } reg_req_t;

    // error-status bits that may raise the error line
    function automatic logic [N_ERR-1:0] err_line_sources();
        logic [N_ERR-1:0] m;
        m = '0;
        m[EB_CMD_BUSY]  = 1'b1;
        m[EB_CMD_INVAL] = 1'b1;
        m[EB_CS_INVAL]  = 1'b1;
        return m;
    endfunction

    // place status levels at their event-enable positions
    function automatic logic [N_EVT-1:0] evt_levels(input logic ready,
                                                    input logic tx_empty,
                                                    input logic rx_full);
        logic [N_EVT-1:0] v;
        v = '0;
        v[EV_READY]    = ready;
        v[EV_TX_EMPTY] = tx_empty;
        v[EV_RX_FULL]  = rx_full;
        return v;
    endfunction

endpackage

// File: rtl/ser_irq_cfg.sv
module ser_irq_cfg
    import ser_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  reg_req_t            req,
    output logic [N_LINE-1:0]   line_en,
    output logic [N_LINE-1:0]   line_en_nxt,
    output logic [N_LINE-1:0]   test_hit,
    output logic [N_LINE-1:0]   pend_clr,
    output logic [N_ERR-1:0]    sts_clr,
    output logic [N_ERR_EN-1:0] err_en,
    output logic [N_EVT-1:0]    evt_en
);

    logic [N_ERR_EN-1:0] err_en_nxt;
    logic [N_EVT-1:0]    evt_en_nxt;

    always_comb begin
        line_en_nxt = line_en;
        err_en_nxt  = err_en;
        evt_en_nxt  = evt_en;
        test_hit    = '0;
        pend_clr    = '0;
        sts_clr     = '0;
        if (req.wr) begin
            case (req.sel)
                RS_STATE:   pend_clr    = req.data[N_LINE-1:0];
                RS_LINE_EN: line_en_nxt = req.data[N_LINE-1:0];
                RS_TEST:    test_hit    = req.data[N_LINE-1:0];
                RS_ERR_EN:  err_en_nxt  = req.data[N_ERR_EN-1:0];
                RS_ERR_STS: sts_clr     = req.data[N_ERR-1:0];
                RS_EVT_EN:  evt_en_nxt  = req.data[N_EVT-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_en <= '0;
            err_en  <= ERR_EN_RESET;
            evt_en  <= '0;
        end else begin
            line_en <= line_en_nxt;
            err_en  <= err_en_nxt;
            evt_en  <= evt_en_nxt;
        end
    end

endmodule

// File: rtl/ser_irq_errsts.sv
module ser_irq_errsts
    import ser_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ERR-1:0] set_pulse,
    input  logic [N_ERR-1:0] clr,
    output logic [N_ERR-1:0] sts
);

    for (genvar i = 0; i < N_ERR; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                sts[i] <= 1'b0;
            else if (set_pulse[i])
                sts[i] <= 1'b1;
            else if (clr[i])
                sts[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/ser_irq_line.sv
module ser_irq_line (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic en_nxt,
    input  logic cause,
    input  logic test,
    input  logic clr,
    output logic pending,
    output logic irq
);

    logic fire;
    logic pend_d;

    always_comb begin
        fire   = en && !pending && (test || cause);
        pend_d = fire || (pending && !clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            irq     <= 1'b0;
        end else begin
            pending <= pend_d;
            irq     <= pend_d && en_nxt;
        end
    end

endmodule

// File: rtl/ser_irq_hub.sv
module ser_irq_hub
    import ser_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_ERR-1:0]  err_pulse,
    input  logic              st_ready,
    input  logic              st_tx_empty,
    input  logic              st_rx_full,
    output logic              irq_error,
    output logic              irq_event
);

    reg_req_t            req;
    logic [N_LINE-1:0]   line_en;
    logic [N_LINE-1:0]   line_en_nxt;
    logic [N_LINE-1:0]   test_hit;
    logic [N_LINE-1:0]   pend_clr;
    logic [N_ERR-1:0]    sts_clr;
    logic [N_ERR_EN-1:0] err_en;
    logic [N_EVT-1:0]    evt_en;
    logic [N_ERR-1:0]    err_sts;
    logic [N_LINE-1:0]   cause;
    logic [N_LINE-1:0]   pending;
    logic [N_LINE-1:0]   irq_vec;

    always_comb begin
        req.wr   = reg_we;
        req.sel  = reg_sel_e'(reg_addr);
        req.data = reg_wdata;
    end

    ser_irq_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .line_en     (line_en),
        .line_en_nxt (line_en_nxt),
        .test_hit    (test_hit),
        .pend_clr    (pend_clr),
        .sts_clr     (sts_clr),
        .err_en      (err_en),
        .evt_en      (evt_en)
    );

    ser_irq_errsts u_sts (
        .clk       (clk),
        .rst       (rst),
        .set_pulse (err_pulse),
        .clr       (sts_clr),
        .sts       (err_sts)
    );

    always_comb begin
        cause[LN_ERR] = |(err_sts & {{(N_ERR - N_ERR_EN){1'b0}}, err_en} & err_line_sources());
        cause[LN_EVT] = |(evt_en & evt_levels(st_ready, st_tx_empty, st_rx_full));
    end

    for (genvar l = 0; l < N_LINE; l++) begin : g_line
        ser_irq_line u_line (
            .clk     (clk),
            .rst     (rst),
            .en      (line_en[l]),
            .en_nxt  (line_en_nxt[l]),
            .cause   (cause[l]),
            .test    (test_hit[l]),
            .clr     (pend_clr[l]),
            .pending (pending[l]),
            .irq     (irq_vec[l])
        );
    end

    assign irq_error = irq_vec[LN_ERR];
    assign irq_event = irq_vec[LN_EVT];

    always_comb begin
        reg_rdata = '0;
        case (req.sel)
            RS_STATE:   reg_rdata[N_LINE-1:0]   = pending;
            RS_LINE_EN: reg_rdata[N_LINE-1:0]   = line_en;
            RS_ERR_EN:  reg_rdata[N_ERR_EN-1:0] = err_en;
            RS_ERR_STS: reg_rdata[N_ERR-1:0]    = err_sts;
            RS_EVT_EN:  reg_rdata[N_EVT-1:0]    = evt_en;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ser_irq_hub_chk.sv
module ser_irq_hub_chk
    import ser_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [N_ERR-1:0]  err_pulse,
    input logic [N_LINE-1:0] line_en,
    input logic [N_ERR-1:0]  err_sts,
    input logic [N_LINE-1:0] pending,
    input logic              irq_error,
    input logic              irq_event
);

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == RS_ERR_STS) |=> ((err_sts & $past(err_sts)) == $past(err_sts))); // R3

    AST_PULSE_WINS: assert property (@(posedge clk) disable iff (rst)
        (err_pulse != '0) |=> ((err_sts & $past(err_pulse)) == $past(err_pulse))); // R4

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pending[LN_ERR] && !(reg_we && reg_addr == RS_STATE && reg_wdata[LN_ERR])) |=> pending[LN_ERR]); // R7

    AST_ERR_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!line_en[LN_ERR] && !pending[LN_ERR]) |=> !pending[LN_ERR]); // R5

    AST_TEST_FORCE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == RS_TEST && reg_wdata[LN_EVT] && line_en[LN_EVT] && !pending[LN_EVT])
        |=> pending[LN_EVT]); // R9

    AST_ERR_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_error == (pending[LN_ERR] && line_en[LN_ERR])); // R10

    AST_EVT_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_event == (pending[LN_EVT] && line_en[LN_EVT])); // R10

endmodule

bind ser_irq_hub ser_irq_hub_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .err_pulse (err_pulse),
    .line_en   (line_en),
    .err_sts   (err_sts),
    .pending   (pending),
    .irq_error (irq_error),
    .irq_event (irq_event)
);

// File: tb/sim_ser_irq_hub.sv
module sim_ser_irq_hub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  err_pulse = '0;
    logic        st_ready = 1'b0;
    logic        st_tx_empty = 1'b0;
    logic        st_rx_full = 1'b0;
    logic        irq_error;
    logic        irq_event;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    ser_irq_hub u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .err_pulse(err_pulse),
        .st_ready(st_ready), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
        .irq_error(irq_error), .irq_event(irq_event)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on every edge
    logic [1:0] m_pend, m_len;
    logic [4:0] m_eren;
    logic [5:0] m_ests, m_even;

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {30'd0, m_pend};
            3'd1: return {30'd0, m_len};
            3'd3: return {27'd0, m_eren};
            3'd4: return {26'd0, m_ests};
            3'd5: return {26'd0, m_even};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pend = '0; m_len = '0; m_eren = 5'h1F; m_ests = '0; m_even = '0;
        end else begin
            logic t_err, t_evt, c_err, c_evt;
            logic [1:0] fire, clr;
            t_err = reg_we && reg_addr == 3'd2 && reg_wdata[0];
            t_evt = reg_we && reg_addr == 3'd2 && reg_wdata[1];
            c_err = (m_eren[0] && m_ests[0]) || (m_eren[3] && m_ests[3]) || (m_eren[4] && m_ests[4]);
            c_evt = (m_even[4] && st_ready) || (m_even[1] && st_tx_empty) || (m_even[0] && st_rx_full);
            fire[0] = m_len[0] && !m_pend[0] && (t_err || c_err);
            fire[1] = m_len[1] && !m_pend[1] && (t_evt || c_evt);
            clr = (reg_we && reg_addr == 3'd0) ? reg_wdata[1:0] : 2'b00;
            m_pend = (m_pend & ~clr) | fire;
            if (reg_we && reg_addr == 3'd4) m_ests = m_ests & ~reg_wdata[5:0];
            m_ests = m_ests | err_pulse;
            if (reg_we && reg_addr == 3'd1) m_len  = reg_wdata[1:0];
            if (reg_we && reg_addr == 3'd3) m_eren = reg_wdata[4:0];
            if (reg_we && reg_addr == 3'd5) m_even = reg_wdata[5:0];
        end
        #2;
        chk("R5 irq_error vs model", {31'd0, irq_error}, {31'd0, m_pend[0] & m_len[0]});
        chk("R6 irq_event vs model", {31'd0, irq_event}, {31'd0, m_pend[1] & m_len[1]});
        chk("R2 rdata vs model", reg_rdata, m_read(reg_addr));
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic wr_pulse(input logic [2:0] a, input logic [31:0] d, input logic [5:0] p);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d; err_pulse = p;
        @(negedge clk); reg_we = 1'b0; err_pulse = '0;
    endtask

    task automatic pulse(input logic [5:0] p);
        @(negedge clk); err_pulse = p;
        @(negedge clk); err_pulse = '0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk); reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 irq_error reset", {31'd0, irq_error}, 32'd0);
        chk("R1 irq_event reset", {31'd0, irq_event}, 32'd0);
        rd("R1 state reset", 3'd0, 32'd0);
        rd("R1 line enable reset", 3'd1, 32'd0);
        rd("R1 error enable reset", 3'd3, 32'h1F);
        rd("R1 error status reset", 3'd4, 32'd0);
        rd("R1 event enable reset", 3'd5, 32'd0);

        // R2 read back masked
        wr(3'd1, 32'hFFFF_FFFF); rd("R2 line enable mask", 3'd1, 32'd3);
        wr(3'd1, 32'd0);
        wr(3'd3, 32'hFFFF_FFFF); rd("R2 error enable mask", 3'd3, 32'h1F);
        wr(3'd5, 32'hFFFF_FFFF); rd("R2 event enable mask", 3'd5, 32'h3F);
        wr(3'd5, 32'd0);
        wr(3'd2, 32'd3);
        rd("R2 test reads zero", 3'd2, 32'd0);
        rd("R9 test with lines off", 3'd0, 32'd0);

        // R11 unmapped addresses
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd("R11 addr 6 reads 0", 3'd6, 32'd0);
        rd("R11 addr 7 reads 0", 3'd7, 32'd0);
        rd("R11 line enable untouched", 3'd1, 32'd0);
        rd("R11 error enable untouched", 3'd3, 32'h1F);

        // R3 sticky error status
        pulse(6'h26);
        rd("R3 pulses set bits", 3'd4, 32'h26);
        idle(3);
        rd("R3 bits stay set", 3'd4, 32'h26);
        wr(3'd4, 32'h04);
        rd("R3 clear one bit", 3'd4, 32'h22);
        wr(3'd4, 32'h3F);
        rd("R3 clear all", 3'd4, 32'd0);

        // R5 non-raising sources
        wr(3'd1, 32'd1);
        pulse(6'h26);
        idle(3);
        chk("R5 overflow/underflow/access quiet", {31'd0, irq_error}, 32'd0);
        rd("R5 state unchanged", 3'd0, 32'd0);
        wr(3'd4, 32'h3F);

        // R4 set wins over clear
        wr_pulse(3'd4, 32'h01, 6'h01);
        rd("R4 pulse beats clear", 3'd4, 32'h01);
        chk("R5 command busy raises", {31'd0, irq_error}, 32'd1);
        rd("R7 pending set", 3'd0, 32'd1);

        // R8 clear with cause present
        wr(3'd0, 32'd1);
        chk("R8 low for one cycle", {31'd0, irq_error}, 32'd0);
        @(negedge clk);
        chk("R8 rises again", {31'd0, irq_error}, 32'd1);
        wr(3'd4, 32'h01);
        wr(3'd0, 32'd1);
        idle(2);
        chk("R7 cleared stays low", {31'd0, irq_error}, 32'd0);
        rd("R7 state cleared", 3'd0, 32'd0);

        // R5 per-source mask
        wr(3'd3, 32'h1E);
        pulse(6'h01);
        idle(2);
        chk("R5 masked source quiet", {31'd0, irq_error}, 32'd0);
        wr(3'd3, 32'h1F);
        idle(1);
        chk("R5 unmask raises", {31'd0, irq_error}, 32'd1);
        wr(3'd4, 32'h3F); wr(3'd0, 32'd1);
        idle(1);
        pulse(6'h10);
        idle(1);
        chk("R5 invalid chip select raises", {31'd0, irq_error}, 32'd1);
        wr(3'd4, 32'h3F); wr(3'd0, 32'd1);

        // R10 enable gates output
        pulse(6'h08);
        idle(1);
        chk("R5 invalid command raises", {31'd0, irq_error}, 32'd1);
        wr(3'd1, 32'd0);
        chk("R10 enable off drops line", {31'd0, irq_error}, 32'd0);
        rd("R10 pending kept", 3'd0, 32'd1);
        wr(3'd1, 32'd1);
        chk("R10 enable on restores", {31'd0, irq_error}, 32'd1);
        wr(3'd4, 32'h3F); wr(3'd0, 32'd1);

        // R6 event line
        wr(3'd1, 32'd2);
        @(negedge clk); st_ready = 1'b1;
        idle(2);
        chk("R6 no event enable quiet", {31'd0, irq_event}, 32'd0);
        wr(3'd5, 32'h2C);
        idle(2);
        chk("R6 watermark/idle bits inert", {31'd0, irq_event}, 32'd0);
        wr(3'd5, 32'h10);
        idle(1);
        chk("R6 ready raises", {31'd0, irq_event}, 32'd1);
        rd("R6 state event bit", 3'd0, 32'd2);
        @(negedge clk); st_ready = 1'b0;
        wr(3'd0, 32'd2);
        idle(2);
        chk("R6 cleared ready low", {31'd0, irq_event}, 32'd0);
        @(negedge clk); st_tx_empty = 1'b1;
        wr(3'd5, 32'h02);
        idle(1);
        chk("R6 tx empty raises", {31'd0, irq_event}, 32'd1);
        @(negedge clk); st_tx_empty = 1'b0;
        wr(3'd0, 32'd2);
        @(negedge clk); st_rx_full = 1'b1;
        wr(3'd5, 32'h01);
        idle(1);
        chk("R6 rx full raises", {31'd0, irq_event}, 32'd1);
        @(negedge clk); st_rx_full = 1'b0;
        wr(3'd0, 32'd2);

        // R9 test force
        wr(3'd2, 32'd2);
        chk("R9 test raises event", {31'd0, irq_event}, 32'd1);
        rd("R9 test reads zero", 3'd2, 32'd0);
        wr(3'd0, 32'd2);
        idle(2);
        chk("R9 test not sticky", {31'd0, irq_event}, 32'd0);
        wr(3'd1, 32'd3);
        wr(3'd2, 32'd1);
        chk("R9 test raises error", {31'd0, irq_error}, 32'd1);
        wr(3'd0, 32'd3);
        idle(1);
        chk("R9 error test cleared", {31'd0, irq_error}, 32'd0);

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule